// File: doc/BRIEF.md
# Key-Guarded Byte Write Controller for a Nonvolatile Data Array

This block sits on a byte-wide register bus and commits single-byte writes into a small nonvolatile data array, which is modelled here as an internal register array. Software loads a two-byte address pointer and a data latch, sets a write-enable bit, and then writes a two-byte key to a guard register. Only after that does setting the start bit in the control register launch a write. The write waits for the fourth falling edge of a slow serial clock input. It then erases the addressed cell to FFh, programs the new byte, and clears the start bit by itself. Software learns that the write is finished by polling that bit.

Any attempt to start a write without a freshly completed key, or with the memory-select field non-zero, is refused and raises a sticky error flag. While a write runs, the pointer, data latch and control register are frozen. A separate read-strobe bit copies the addressed cell into the data latch so that the array can be read back.

Register offsets on `bus_addr` are: 0 pointer low byte, 1 pointer high bits, 2 data latch, 3 control, 4 key register. Offsets 5 to 7 read as 00h. Control bits are: [7:6] memory select, [3] error (write 1 to clear), [2] write enable, [1] start/busy, [0] read strobe (self-clearing, reads 0). `bus_rdata` always shows the register at `bus_addr`. An access is any cycle with `bus_we` or `bus_re` high.

Top module: `eewr_ctrl`

## Requirements
- R1: After reset, the pointer, data latch and control register read 00h and every array cell holds FFh.
- R2: The pointer low byte and data latch read back what was written, and the pointer high register keeps only its low ADDR_W-8 bits (01h after writing FFh with the default ADDR_W of 9).
- R3: The key register (offset 4) always reads 00h.
- R4: Writing 55h and then AAh to offset 4 as the last two accesses, followed by a control write with bit 1 set, bits 7:6 equal to 00 and write enable already 1 from an earlier control write, sets control bit 1 on the following clock edge.
- R5: The write holds until the fourth sclk falling edge seen after start. Bit 1 then clears exactly ERASE_CYC+PROG_CYC clocks after the clock edge that samples that fourth fall.
- R6: The write first sets the addressed cell to FFh (erase), then stores the data latch value (program). After completion, a read strobe returns the new byte.
- R7: A start attempt with write enable 1 but without a valid key (wrong order, or any other bus access between the keys and the control write) sets error bit 3, leaves bit 1 at 0 and leaves the array unchanged.
- R8: A start attempt with a valid key but bits 7:6 not equal to 00 sets error bit 3 and does not write the array.
- R9: Setting bit 1 while write enable is 0 does nothing: bit 1 stays 0, no error is raised and the array is unchanged.
- R10: The error bit stays set across other accesses until a control write with bit 3 set clears it.
- R11: While bit 1 reads 1, bus writes to the pointer, data latch and control register have no effect.
- R12: A control write with bit 0 set and bit 1 clear loads the data latch with the addressed cell on the next edge.
- R13: The key state returns to idle after a completed write or a refused attempt, so a lone AAh followed by a start attempt is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (counts as an access) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at bus_addr |
| sclk | input | 1 | Serial timing clock, sampled by clk |

## Verification
All register effects of a bus access appear one clock after the edge that samples the access. Every `bus_rdata` value is therefore compared 1 ns after each rising edge against a behavioural model that was stepped on that same edge. An sclk fall is counted on the first clock edge that samples the low level. The end of the write is therefore checked edge by edge, starting from the edge after the fourth low level is driven: bit 1 must still read 1 for ERASE_CYC+PROG_CYC-1 more edges and read 0 on the next. The erase-to-FFh step cannot be seen at the ports. A bound property ties it to the array write port, and the bench checks the programmed byte through the read strobe after the write completes.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    RA_ALO  = 3'd0,
    RA_AHI  = 3'd1,
    RA_DATA = 3'd2,
    RA_CTRL = 3'd3,
    RA_KEY  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    K_IDLE  = 2'd0,
    K_HALF  = 2'd1,
    K_ARMED = 2'd2
  } key_st_e;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_WAIT  = 2'd1,
    W_ERASE = 2'd2,
    W_PROG  = 2'd3
  } wr_st_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;

  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_WEN = 2;
  localparam int CB_ERR = 3;

  function automatic key_st_e key_step(key_st_e cur, logic access, logic key_wr,
                                       logic [7:0] wd);
    key_st_e nxt;
    nxt = cur;
    if (access) begin
      if (key_wr && wd == KEY_FIRST)                      nxt = K_HALF;
      else if (key_wr && wd == KEY_SECOND && cur == K_HALF) nxt = K_ARMED;
      else                                                 nxt = K_IDLE;
    end
    return nxt;
  endfunction

  function automatic logic [7:0] ctrl_image(logic [1:0] sel, logic err, logic wen,
                                            logic wr);
    return {sel, 2'b00, err, wen, wr, 1'b0};
  endfunction

endpackage

// File: rtl/eewr_keyseq.sv
module eewr_keyseq
  import eewr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       access,
  input  logic       key_wr,
  input  logic [7:0] wdata,
  output logic       armed
);
  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    st_q <= K_IDLE;
    else if (hold) st_q <= K_IDLE;
    else           st_q <= key_step(st_q, access, key_wr, wdata);
  end

  assign armed = (st_q == K_ARMED);
endmodule

// File: rtl/eewr_wrseq.sv
module eewr_wrseq
  import eewr_pkg::*;
#(
  parameter int ERASE_CYC  = 5,
  parameter int PROG_CYC   = 7,
  parameter int SCLK_FALLS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sclk_fall,
  output logic busy,
  output logic erase_done,
  output logic prog_done
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ?
                         ((ERASE_CYC > SCLK_FALLS) ? ERASE_CYC : SCLK_FALLS) :
                         ((PROG_CYC > SCLK_FALLS) ? PROG_CYC : SCLK_FALLS);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] FALL_LAST  = CNT_W'(SCLK_FALLS - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);

  wr_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (start) begin
          st_q  <= W_WAIT;
          cnt_q <= '0;
        end
        W_WAIT: if (sclk_fall) begin
          if (cnt_q == FALL_LAST) begin
            st_q  <= W_ERASE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        W_ERASE: if (cnt_q == ERASE_LAST) begin
          st_q  <= W_PROG;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        W_PROG: if (cnt_q == PROG_LAST) begin
          st_q  <= W_IDLE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != W_IDLE);
  assign erase_done = (st_q == W_ERASE) && (cnt_q == ERASE_LAST);
  assign prog_done  = (st_q == W_PROG)  && (cnt_q == PROG_LAST);
endmodule

// File: rtl/eewr_array.sv
module eewr_array
  import eewr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= ERASED;
    end else if (we) begin
      cell_q[addr] <= wdata;
    end
  end

  assign rdata = cell_q[addr];
endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
  import eewr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int ERASE_CYC  = 5,
  parameter int PROG_CYC   = 7,
  parameter int SCLK_FALLS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sclk
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0]      addr_lo_q;
  logic [HI_W-1:0] addr_hi_q;
  logic [7:0]      data_q;
  logic [1:0]      sel_q;
  logic            wen_q;
  logic            err_q;
  logic            sclk_q;

  logic              wr_busy, erase_done, prog_done, key_armed;
  logic              sclk_fall, access, ctrl_wr, key_wr;
  logic              wr_req, sel_ok, wr_start, wr_reject, err_clr, rd_req;
  logic              arr_we;
  logic [7:0]        arr_wdata, arr_rdata;
  logic [ADDR_W-1:0] addr_word;

  assign addr_word = {addr_hi_q, addr_lo_q};
  assign access    = bus_we | bus_re;
  assign sclk_fall = sclk_q & ~sclk;
  assign key_wr    = bus_we && (bus_addr == RA_KEY);
  assign ctrl_wr   = bus_we && (bus_addr == RA_CTRL) && !wr_busy;
  assign wr_req    = ctrl_wr && bus_wdata[CB_WR] && wen_q;
  assign sel_ok    = (bus_wdata[7:6] == 2'b00);
  assign wr_start  = wr_req && key_armed && sel_ok;
  assign wr_reject = wr_req && !(key_armed && sel_ok);
  assign err_clr   = ctrl_wr && bus_wdata[CB_ERR];
  assign rd_req    = ctrl_wr && bus_wdata[CB_RD] && !bus_wdata[CB_WR];

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      data_q    <= '0;
      sel_q     <= '0;
      wen_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= (err_q && !err_clr) || wr_reject;
      if (bus_we && !wr_busy) begin
        unique case (bus_addr)
          RA_ALO:  addr_lo_q <= bus_wdata;
          RA_AHI:  addr_hi_q <= bus_wdata[HI_W-1:0];
          RA_DATA: data_q    <= bus_wdata;
          RA_CTRL: begin
            sel_q <= bus_wdata[7:6];
            wen_q <= bus_wdata[CB_WEN];
            if (rd_req) data_q <= arr_rdata;
          end
          default: ;
        endcase
      end
    end
  end

  eewr_keyseq u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (wr_busy),
    .access (access),
    .key_wr (key_wr),
    .wdata  (bus_wdata),
    .armed  (key_armed)
  );

  eewr_wrseq #(
    .ERASE_CYC  (ERASE_CYC),
    .PROG_CYC   (PROG_CYC),
    .SCLK_FALLS (SCLK_FALLS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_start),
    .sclk_fall  (sclk_fall),
    .busy       (wr_busy),
    .erase_done (erase_done),
    .prog_done  (prog_done)
  );

  assign arr_we    = erase_done | prog_done;
  assign arr_wdata = erase_done ? ERASED : data_q;

  eewr_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .addr  (addr_word),
    .wdata (arr_wdata),
    .rdata (arr_rdata)
  );

  always_comb begin
    unique case (bus_addr)
      RA_ALO:  bus_rdata = addr_lo_q;
      RA_AHI:  bus_rdata = 8'(addr_hi_q);
      RA_DATA: bus_rdata = data_q;
      RA_CTRL: bus_rdata = ctrl_image(sel_q, err_q, wen_q, wr_busy);
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/eewr_ctrl_chk.sv
module eewr_ctrl_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              key_armed,
  input logic              wr_reject,
  input logic              erase_done,
  input logic              prog_done,
  input logic              arr_we,
  input logic [7:0]        arr_wdata,
  input logic              wr_busy,
  input logic              err_q,
  input logic              err_clr,
  input logic [ADDR_W-1:0] addr_word,
  input logic [7:0]        data_q
);
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 3'd4 |-> bus_rdata == 8'h00); // R3

  AST_ARM_AFTER_SECOND_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_armed) |-> $past(bus_we && bus_addr == 3'd4 && bus_wdata == 8'hAA)); // R4

  AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> arr_we && arr_wdata == 8'hFF); // R6

  AST_BUSY_DROPS_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wr_busy); // R6

  AST_REJECT_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> err_q); // R7

  AST_NO_ARRAY_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |-> !arr_we); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q); // R10

  AST_BUSY_FREEZES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> $stable(addr_word) && $stable(data_q)); // R11
endmodule

bind eewr_ctrl eewr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .key_armed  (key_armed),
  .wr_reject  (wr_reject),
  .erase_done (erase_done),
  .prog_done  (prog_done),
  .arr_we     (arr_we),
  .arr_wdata  (arr_wdata),
  .wr_busy    (wr_busy),
  .err_q      (err_q),
  .err_clr    (err_clr),
  .addr_word  (addr_word),
  .data_q     (data_q)
);

// File: tb/tb_eewr_ctrl.sv
`timescale 1ns/1ps
module tb_eewr_ctrl;
  localparam int ADDR_W = 9;
  localparam int ERASE  = 5;
  localparam int PROG   = 7;
  localparam int FALLS  = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_MASK = (1 << (ADDR_W - 8)) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0, bus_re = 1'b0, sclk = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  always #2 clk = ~clk;

  eewr_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE), .PROG_CYC(PROG), .SCLK_FALLS(FALLS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mem [DEPTH];
  int m_alo, m_ahi, m_data, m_sel, m_wen, m_err, m_busy, m_key, m_ph, m_cnt, m_falls, m_sq;

  function automatic int m_read(input int a);
    case (a)
      0: return m_alo;
      1: return m_ahi;
      2: return m_data;
      3: return (m_sel << 6) | (m_err << 3) | (m_wen << 2) | (m_busy << 1);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int wd, nk, ma;
    bit fall;
    wd = int'(bus_wdata);
    ma = m_alo + 256 * m_ahi;
    if (!rst_n) begin
      m_alo = 0; m_ahi = 0; m_data = 0; m_sel = 0; m_wen = 0; m_err = 0;
      m_busy = 0; m_key = 0; m_ph = 0; m_cnt = 0; m_falls = 0; m_sq = 0;
      foreach (mem[i]) mem[i] = 8'hFF;
    end else begin
      fall = (m_sq == 1) && (sclk == 1'b0);
      m_sq = int'(sclk);
      if (m_busy == 1) begin
        m_key = 0;
        if (m_ph == 0) begin
          if (fall) begin
            m_falls++;
            if (m_falls == FALLS) begin m_ph = 1; m_cnt = 0; end
          end
        end else if (m_ph == 1) begin
          m_cnt++;
          if (m_cnt == ERASE) begin mem[ma] = 8'hFF; m_ph = 2; m_cnt = 0; end
        end else begin
          m_cnt++;
          if (m_cnt == PROG) begin mem[ma] = m_data; m_busy = 0; end
        end
      end else if (bus_we || bus_re) begin
        nk = 0;
        if (bus_we) begin
          case (int'(bus_addr))
            0: m_alo = wd;
            1: m_ahi = wd & HI_MASK;
            2: m_data = wd;
            3: begin
              if (wd[3]) m_err = 0;
              if (wd[1] && m_wen == 1) begin
                if (m_key == 2 && wd[7:6] == 0) begin
                  m_busy = 1; m_ph = 0; m_falls = 0;
                end else m_err = 1;
              end
              if (wd[0] && !wd[1]) m_data = mem[ma];
              m_sel = (wd >> 6) & 3;
              m_wen = wd[2];
            end
            4: begin
              if (wd == 8'h55) nk = 1;
              else if (wd == 8'hAA && m_key == 1) nk = 2;
            end
            default: ;
          endcase
        end
        m_key = nk;
      end
    end
  end

  // compare on every clock
  always @(posedge clk) begin
    #1;
    if (rst_n && !done)
      check(bus_addr == 3'd3 ? "R4 ctrl" : bus_addr == 3'd4 ? "R3 key" : "R2 reg",
            int'(bus_rdata), m_read(int'(bus_addr)));
  end

  task automatic bus(input bit we, input bit re, input int a, input int d);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = 3'(a); bus_wdata = 8'(d);
  endtask

  task automatic peek(input int a, output int v);
    bus(0, 0, a, 0);
    @(posedge clk); #1;
    v = int'(bus_rdata);
  endtask

  task automatic sclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic set_addr(input int a);
    bus(1, 0, 0, a & 255);
    bus(1, 0, 1, a >> 8);
  endtask

  task automatic read_cell(input int a, output int v);
    set_addr(a);
    bus(1, 0, 3, 8'h05);
    peek(2, v);
  endtask

  task automatic wait_idle();
    int v;
    for (int i = 0; i < 60; i++) begin
      peek(3, v);
      if (!v[1]) break;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(3, v); check("R1 ctrl", v, 0);
    peek(0, v); check("R1 alo", v, 0);
    peek(2, v); check("R1 data", v, 0);
    read_cell(9'h1A5, v); check("R1 cell erased", v, 8'hFF);
    // R2 readback, high register width
    bus(1, 0, 0, 8'h3C); peek(0, v); check("R2 alo", v, 8'h3C);
    bus(1, 0, 1, 8'hFF); peek(1, v); check("R2 ahi masked", v, 8'h01);
    bus(1, 0, 2, 8'hC3); peek(2, v); check("R2 data", v, 8'hC3);
    // R3 key reads zero even after writes
    bus(1, 0, 4, 8'h55); peek(4, v); check("R3 key", v, 0);
    // R4 R5 R6 valid write with timing
    set_addr(9'h123);
    bus(1, 0, 2, 8'h5A);
    bus(1, 0, 3, 8'h04);
    bus(1, 0, 4, 8'h55);
    bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h06);
    peek(3, v); check("R4 start", v, 8'h06);
    sclk_pulses(FALLS - 1);
    @(negedge clk); sclk = 1'b1;
    // R11 writes ignored while busy
    bus(1, 0, 2, 8'h11);
    bus(1, 0, 0, 8'h00);
    bus(1, 0, 3, 8'h00);
    @(negedge clk); bus_we = 1'b0; bus_addr = 3'd2;
    @(posedge clk); #1; check("R11 data frozen", int'(bus_rdata), 8'h5A);
    @(negedge clk); bus_addr = 3'd3; sclk = 1'b0;
    for (int j = 0; j <= ERASE + PROG; j++) begin
      @(posedge clk); #1;
      check("R5 busy timing", int'(bus_rdata[1]), (j < ERASE + PROG) ? 1 : 0);
    end
    peek(0, v); check("R11 addr frozen", v, 8'h23);
    read_cell(9'h123, v); check("R6 programmed", v, 8'h5A);
    check("R12 readback", v, 8'h5A);
    read_cell(9'h124, v); check("R12 neighbour", v, 8'hFF);
    // R13 lone second key after completed write
    set_addr(9'h010);
    bus(1, 0, 2, 8'h77);
    bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h06);
    peek(3, v); check("R13 refused", v, 8'h0C);
    // R10 sticky over accesses, then clear
    bus(0, 1, 0, 0); bus(1, 0, 2, 8'h77);
    peek(3, v); check("R10 sticky", v, 8'h0C);
    bus(1, 0, 3, 8'h0C);
    peek(3, v); check("R10 cleared", v, 8'h04);
    // R7 intervening access
    bus(1, 0, 4, 8'h55); bus(0, 1, 0, 0); bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h06);
    peek(3, v); check("R7 intervening", v, 8'h0C);
    bus(1, 0, 3, 8'h0C);
    // R7 wrong order
    bus(1, 0, 4, 8'hAA); bus(1, 0, 4, 8'h55);
    bus(1, 0, 3, 8'h06);
    peek(3, v); check("R7 order", v, 8'h0C);
    sclk_pulses(FALLS + 1);
    repeat (ERASE + PROG + 2) @(negedge clk);
    read_cell(9'h010, v); check("R7 no write", v, 8'hFF);
    bus(1, 0, 3, 8'h0C);
    // R8 select bits nonzero
    bus(1, 0, 2, 8'h77);
    bus(1, 0, 4, 8'h55); bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h46);
    peek(3, v); check("R8 select", v, 8'h4C);
    sclk_pulses(FALLS + 1);
    repeat (ERASE + PROG + 2) @(negedge clk);
    read_cell(9'h010, v); check("R8 no write", v, 8'hFF);
    bus(1, 0, 3, 8'h08);
    // R9 write enable clear
    bus(1, 0, 2, 8'h99);
    bus(1, 0, 4, 8'h55); bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h02);
    peek(3, v); check("R9 ignored", v, 8'h00);
    sclk_pulses(FALLS + 1);
    repeat (ERASE + PROG + 2) @(negedge clk);
    read_cell(9'h010, v); check("R9 no write", v, 8'hFF);
    // second valid write, sclk running, overwrite
    bus(1, 0, 3, 8'h04);
    bus(1, 0, 2, 8'h00);
    bus(1, 0, 4, 8'h55); bus(1, 0, 4, 8'hAA);
    bus(1, 0, 3, 8'h06);
    sclk_pulses(FALLS);
    wait_idle();
    read_cell(9'h010, v); check("R6 zero byte", v, 8'h00);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule